// File: doc/BRIEF.md
# Accelerometer SPI Register Target

This block is a synthesizable SPI target that plays the part of a three-axis accelerometer. A master-side driver under test can be aimed at it in simulation, or looped back to it in hardware, and it answers the way a simple motion sensor would. Each transaction opens with a command byte and an address byte. A write stores one data byte. A read returns register bytes from successive addresses for as long as the master keeps clocking.

The three axis samples come in on parallel ports, and the target samples them continuously. These ports have no handshake and apply no back-pressure, because the target takes a fresh copy whenever chip select falls. That copy is served as little-endian byte pairs. A level output shows whether measurement mode has been switched on through the power-control register, and a one-cycle pulse marks every completed write.

All SPI pins are brought into the system clock through synchroniser chains, and edges are detected there. The SPI mode is clock idle low, with data sampled on the rising edge and shifted out on the falling edge, most significant bit first.

Top module: `accel_spi_target`

## Requirements
- R1: After reset, `spi_miso`, `meas_en` and `wr_pulse` are all 0.
- R2: The byte sequence 0x0A, 0x2D, d written inside one chip-select-low window stores d in the power-control register. `meas_en` then equals bit 1 of d, so 0x02 enables measurement and 0x00 disables it.
- R3: Each completed write (command 0x0A, address, data byte) raises `wr_pulse` for exactly one system clock, whatever the address.
- R4: The sequence 0x0B, 0x0E followed by six further bytes returns X[7:0], X[15:8], Y[7:0], Y[15:8], Z[7:0], Z[15:8] on `spi_miso`, MSB first.
- R5: In a read, the address advances by one after each returned byte. Reading address 0x2D returns the power-control register. Addresses other than 0x0E..0x13 and 0x2D return 0x00, including addresses reached by running past 0x13.
- R6: The axis values are captured when chip select falls. Changes on the axis ports while chip select stays low do not alter the bytes of the burst in progress.
- R7: A command byte other than 0x0A or 0x0B makes the rest of the transaction ignored. `spi_miso` stays 0, no register changes and no `wr_pulse` is raised.
- R8: Raising chip select in the middle of a byte discards that partial byte and the transaction state, and the next transaction decodes from its first bit.
- R9: `spi_miso` is 0 while chip select is high and during the command and address bytes.
- R10: A write to any address other than 0x2D leaves the power-control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| axis_x | input | AXIS_W | X-axis sample |
| axis_y | input | AXIS_W | Y-axis sample |
| axis_z | input | AXIS_W | Z-axis sample |
| meas_en | output | 1 | Bit 1 of the power-control register |
| wr_pulse | output | 1 | One-cycle pulse per completed write |

## Verification
The bench builds the block with its defaults, which are a two-stage synchroniser and 16-bit axes. This gives the six-byte axis window at 0x0E..0x13 and lets reads run off its end into unimplemented space. The serial clock holds each level for eight system clocks, so the synchroniser latency of about three cycles fits comfortably inside every half period. That margin is what makes mid-burst changes on the axis ports and mid-byte chip-select aborts observable at exact bit positions.

// File: rtl/accel_spi_pkg.sv
package accel_spi_pkg;
  localparam logic [7:0] OP_WRITE   = 8'h0A;
  localparam logic [7:0] OP_READ    = 8'h0B;
  localparam logic [7:0] ADDR_PWR   = 8'h2D;
  localparam logic [7:0] ADDR_AXIS0 = 8'h0E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WR_DATA,
    ST_RD_DATA,
    ST_IGNORE
  } xact_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_high,
  output logic cs_high_q,
  output logic mosi_s
);
  localparam int NSIG = 3;
  // bit order {sclk, cs_n, mosi}; chip select resets inactive
  localparam logic [NSIG-1:0] PIN_RST = 3'b010;

  logic [NSIG-1:0] pins_raw;
  logic [NSIG-1:0] pins_s;
  logic [SYNC_STAGES-1:0] chain [NSIG];
  logic sclk_q;

  assign pins_raw = {sclk_in, cs_n_in, mosi_in};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {SYNC_STAGES{PIN_RST[g]}};
      else        chain[g] <= {chain[g][SYNC_STAGES-2:0], pins_raw[g]};
    end
    assign pins_s[g] = chain[g][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_high_q <= 1'b1;
    end else begin
      sclk_q    <= pins_s[2];
      cs_high_q <= pins_s[1];
    end
  end

  assign sclk_rise = pins_s[2] & ~sclk_q;
  assign sclk_fall = ~pins_s[2] & sclk_q;
  assign cs_high   = pins_s[1];
  assign cs_fall   = cs_high_q & ~pins_s[1];
  assign mosi_s    = pins_s[0];
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       tx_bit
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  assign byte_done = sclk_rise && !clear && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi};
  assign tx_bit    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
      end
      // a falling edge right after a byte boundary must not consume the fresh MSB
      if (load)                            tx_sh <= load_byte;
      else if (sclk_fall && bit_cnt != 0)  tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/accel_regs.sv
module accel_regs
  import accel_spi_pkg::*;
#(
  parameter int AXIS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [AXIS_W-1:0] axis_x,
  input  logic [AXIS_W-1:0] axis_y,
  input  logic [AXIS_W-1:0] axis_z,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              meas_en
);
  localparam int AXIS_BYTES   = AXIS_W / 8;
  localparam int SHADOW_BYTES = 3 * AXIS_BYTES;
  localparam int IDX_W        = $clog2(SHADOW_BYTES);
  localparam logic [7:0] SHADOW_N = 8'(SHADOW_BYTES);

  logic [3*AXIS_W-1:0] flat;
  logic [7:0] shadow [SHADOW_BYTES];
  logic [7:0] pwr_reg;
  logic [7:0] off;

  assign flat = {axis_z, axis_y, axis_x};

  for (genvar g = 0; g < SHADOW_BYTES; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shadow[g] <= '0;
      else if (capture) shadow[g] <= flat[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pwr_reg <= '0;
    else if (wr_en && wr_addr == ADDR_PWR)  pwr_reg <= wr_data;
  end

  assign off = rd_addr - ADDR_AXIS0;

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_PWR)                          rd_data = pwr_reg;
    else if (rd_addr >= ADDR_AXIS0 && off < SHADOW_N) rd_data = shadow[off[IDX_W-1:0]];
  end

  assign meas_en = pwr_reg[1];

  assert_pwr_only_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_reg) |-> ($past(wr_en) && $past(wr_addr) == ADDR_PWR));
  assert_meas_tracks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_PWR) |=> (meas_en == $past(wr_data[1])));
endmodule

// File: rtl/accel_spi_target.sv
module accel_spi_target
  import accel_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AXIS_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [AXIS_W-1:0] axis_x,
  input  logic [AXIS_W-1:0] axis_y,
  input  logic [AXIS_W-1:0] axis_z,
  output logic              meas_en,
  output logic              wr_pulse
);
  logic sclk_rise, sclk_fall, cs_fall, cs_high, cs_high_q, mosi_s;
  logic byte_done, tx_bit, load;
  logic [7:0] rx_byte, rd_addr, rd_data, ptr;
  logic wr_en, is_read;
  xact_state_t state;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_high(cs_high), .cs_high_q(cs_high_q), .mosi_s(mosi_s)
  );

  assign rd_addr = (state == ST_ADDR) ? rx_byte : ptr;
  assign load    = byte_done && ((state == ST_ADDR && is_read) || state == ST_RD_DATA);
  assign wr_en   = byte_done && (state == ST_WR_DATA);

  spi_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cs_high),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
    .load(load), .load_byte(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  accel_regs #(.AXIS_W(AXIS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .capture(cs_fall),
    .axis_x(axis_x), .axis_y(axis_y), .axis_z(axis_z),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .meas_en(meas_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_read  <= 1'b0;
      ptr      <= '0;
      wr_pulse <= 1'b0;
    end else begin
      wr_pulse <= wr_en;
      if (cs_fall) begin
        state <= ST_CMD;
      end else if (cs_high) begin
        state <= ST_IDLE;
      end else if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            if (rx_byte == OP_WRITE) begin
              is_read <= 1'b0;
              state   <= ST_ADDR;
            end else if (rx_byte == OP_READ) begin
              is_read <= 1'b1;
              state   <= ST_ADDR;
            end else begin
              state   <= ST_IGNORE;
            end
          end
          ST_ADDR: begin
            if (is_read) begin
              ptr   <= rx_byte + 8'd1;
              state <= ST_RD_DATA;
            end else begin
              ptr   <= rx_byte;
              state <= ST_WR_DATA;
            end
          end
          ST_WR_DATA: state <= ST_IGNORE;
          ST_RD_DATA: ptr   <= ptr + 8'd1;
          default: ;
        endcase
      end
    end
  end

  assign spi_miso = (state == ST_RD_DATA) ? tx_bit : 1'b0;

  assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  assert_pulse_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> ($past(state) == ST_WR_DATA));
  assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_high && cs_high_q) |-> !spi_miso);
  assert_header_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD || state == ST_ADDR) |-> !spi_miso);
endmodule

// File: tb/accel_spi_target_bench.sv
module accel_spi_target_bench;
  localparam int HALF = 8;
  localparam logic [47:0] VEC [4] = '{
    48'h053C_042B_031A, 48'h0345_0234_0123,
    48'h0001_8000_FFFF, 48'hAA55_00FF_7F00
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, meas_en, wr_pulse;
  logic [15:0] ax = '0, ay = '0, az = '0;
  int n_chk = 0, n_fail = 0, pulses = 0;
  logic [7:0] rbuf [16];
  logic [7:0] hdr_or;

  always #10 clk = ~clk;

  accel_spi_target u_accel_spi_target (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .axis_x(ax), .axis_y(ay), .axis_z(az),
    .meas_en(meas_en), .wr_pulse(wr_pulse)
  );

  always @(negedge clk) if (rst_n && wr_pulse) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wclk(HALF);
      sclk = 1'b1;
      rx[i] = miso;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic cs_off();
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2 * HALF);
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [7:0] addr, input logic [7:0] d);
    logic [7:0] r0, r1, r2;
    cs_on();
    xfer(cmd, r0); xfer(addr, r1); xfer(d, r2);
    cs_off();
    hdr_or = r0 | r1 | r2;
  endtask

  task automatic read_burst(input logic [7:0] addr, input int n);
    logic [7:0] r0, r1;
    cs_on();
    xfer(8'h0B, r0); xfer(addr, r1);
    hdr_or = r0 | r1;
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    cs_off();
  endtask

  initial begin
    wclk(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int p0;
    wclk(4);
    // R1 reset state
    chk("R1 miso", {31'd0, miso}, 0);
    chk("R1 meas_en", {31'd0, meas_en}, 0);
    chk("R1 wr_pulse", {31'd0, wr_pulse}, 0);
    rst_n = 1'b1;
    wclk(4);
    chk("R9 miso cs high", {31'd0, miso}, 0);

    // R2 enable measurement, R3 one pulse
    p0 = pulses;
    write_reg(8'h0A, 8'h2D, 8'h02);
    chk("R2 meas_en on", {31'd0, meas_en}, 1);
    chk("R3 pulse count", pulses - p0, 1);
    chk("R9 header miso", {24'd0, hdr_or}, 0);

    // table of axis vectors, R4
    for (int v = 0; v < 4; v++) begin
      {az, ay, ax} = VEC[v];
      wclk(2);
      read_burst(8'h0E, 6);
      chk("R4 x", {16'd0, rbuf[1], rbuf[0]}, {16'd0, VEC[v][15:0]});
      chk("R4 y", {16'd0, rbuf[3], rbuf[2]}, {16'd0, VEC[v][31:16]});
      chk("R4 z", {16'd0, rbuf[5], rbuf[4]}, {16'd0, VEC[v][47:32]});
      chk("R9 read header", {24'd0, hdr_or}, 0);
    end

    // R5 power register readback and run past axis window
    read_burst(8'h2D, 1);
    chk("R5 pwr readback", {24'd0, rbuf[0]}, 32'h02);
    {az, ay, ax} = 48'h1122_3344_5566;
    wclk(2);
    read_burst(8'h12, 4);
    chk("R5 z lo", {24'd0, rbuf[0]}, 32'h22);
    chk("R5 z hi", {24'd0, rbuf[1]}, 32'h11);
    chk("R5 past end", {16'd0, rbuf[2], rbuf[3]}, 0);

    // R6 shadow coherency
    {az, ay, ax} = 48'h0C0B_0A09_0807;
    wclk(2);
    cs_on();
    xfer(8'h0B, rx); xfer(8'h0E, rx);
    xfer(8'h00, rbuf[0]);
    {az, ay, ax} = 48'hFFFF_FFFF_FFFF;
    for (int i = 1; i < 6; i++) xfer(8'h00, rbuf[i]);
    cs_off();
    chk("R6 x", {16'd0, rbuf[1], rbuf[0]}, 32'h0807);
    chk("R6 z", {16'd0, rbuf[5], rbuf[4]}, 32'h0C0B);

    // R7 unknown command
    p0 = pulses;
    write_reg(8'h55, 8'h2D, 8'h00);
    chk("R7 meas_en kept", {31'd0, meas_en}, 1);
    chk("R7 no pulse", pulses - p0, 0);
    chk("R7 miso quiet", {24'd0, hdr_or}, 0);

    // R10 write elsewhere, R3 pulse still
    p0 = pulses;
    write_reg(8'h0A, 8'h20, 8'hFF);
    chk("R3 pulse other addr", pulses - p0, 1);
    chk("R10 meas_en kept", {31'd0, meas_en}, 1);
    read_burst(8'h2D, 1);
    chk("R10 pwr unchanged", {24'd0, rbuf[0]}, 32'h02);

    // R8 abort mid-byte then clean write
    cs_on();
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
    end
    cs_off();
    write_reg(8'h0A, 8'h2D, 8'h00);
    chk("R8 decode after abort", {31'd0, meas_en}, 0);
    // R8 abort inside read data, then fresh read
    {az, ay, ax} = 48'h0000_0000_00A5;
    wclk(2);
    cs_on();
    xfer(8'h0B, rx); xfer(8'h0E, rx);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b0; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
    end
    cs_off();
    chk("R9 miso after abort", {31'd0, miso}, 0);
    read_burst(8'h0E, 1);
    chk("R8 read after abort", {24'd0, rbuf[0]}, 32'hA5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule